// File: doc/BRIEF.md
# Framed Serial DAC Code Receiver

This block accepts DAC codes over a three-wire serial link made of a serial clock, a data line and an active-low frame enable. All three pins are brought into the system clock domain through a synchronizer. The serial clock's falling edges are then found by comparing the synchronized clock against its value one cycle earlier.

While the frame enable is low, each falling serial-clock edge shifts one data bit into a shift register, most significant bit first. When the last bit of a full frame arrives, the assembled word is copied to a parallel DAC-code output and a one-cycle update strobe is raised. A frame is 16 bits or 24 bits long, chosen by a parameter.

If the frame enable goes high before the last bit, the partial word is dropped and the DAC code keeps its value. After a frame completes, further serial-clock edges are ignored until the frame enable goes high and then low again.

The output is a plain register with a strobe. It has no back-pressure, because the serial source cannot be paused. The consumer must take the code in the cycle the strobe is high, or read the held register at any later time.

Top module: `dac_serial_in`

## Requirements
- R1: A synchronous active-high reset drives the DAC code to zero and holds the update strobe low.
- R2: Bits are sampled on falling serial-clock edges while the frame enable is low. The first bit of the frame lands in the most significant position of the DAC code.
- R3: The update strobe is high for exactly one system clock cycle per completed frame. The DAC code changes only in a cycle where the strobe is high.
- R4: Parameter WIDE_FRAME set to 0 gives 16-bit frames and a 16-bit code. Set to 1, it gives 24-bit frames and a 24-bit code.
- R5: If the frame enable rises before the last falling edge of a frame, no strobe is raised and the DAC code keeps its previous value.
- R6: After a frame completes, further falling edges in the same frame have no effect on the code or the strobe.
- R7: Whenever the frame enable is high, the bit count returns to zero. The next frame is assembled from its own bits only.
- R8: Serial-clock edges while the frame enable is high change neither the DAC code nor the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| frame_n | input | 1 | Active-low frame enable |
| dac_code | output | FRAME_BITS (16 or 24) | Last completed DAC code |
| update_pulse | output | 1 | One-cycle strobe when dac_code is loaded |

## Verification
The assertions assume that each level of the serial clock, and the data around each falling edge, lasts at least three system clock cycles. Under that assumption the synchronizer passes every edge, in order, with the data that belongs to it. At a 200 MHz system clock this covers serial rates up to 30 MHz.

The stimulus holds each serial-clock level for four system cycles. It changes the data only at rising serial-clock edges, and the frame enable only while the serial clock is idle. Every edge the assertions reason about is therefore one the block can resolve.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;

  typedef struct packed {
    logic sclk;
    logic sdata;
    logic frame_n;
  } serial_pins_t;

  localparam serial_pins_t PINS_IDLE = '{sclk: 1'b0, sdata: 1'b0, frame_n: 1'b1};

  function automatic int frame_len(input bit wide);
    return wide ? 24 : 16;
  endfunction

endpackage

// File: rtl/dac_serial_sync.sv
module dac_serial_sync
  import dac_serial_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  serial_pins_t pins_in,
  output serial_pins_t pins_out
);

  serial_pins_t chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= PINS_IDLE;
    end else begin
      chain_q[0] <= pins_in;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign pins_out = chain_q[STAGES-1];

endmodule

// File: rtl/dac_serial_edge.sv
module dac_serial_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  output logic sclk_fall
);

  logic sclk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev_q <= 1'b0;
    else     sclk_prev_q <= sclk_s;
  end

  assign sclk_fall = sclk_prev_q & ~sclk_s;

endmodule

// File: rtl/dac_serial_shifter.sv
module dac_serial_shifter #(
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_n_s,
  input  logic                  sdata_s,
  input  logic                  sclk_fall,
  output logic                  load,
  output logic [FRAME_BITS-1:0] word,
  output logic [CNT_W-1:0]      bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-2:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  shift_en;

  assign shift_en = ~frame_n_s & sclk_fall & (cnt_q != CNT_FULL);
  assign load     = shift_en & (cnt_q == CNT_LAST);
  assign word     = {shreg_q, sdata_s};
  assign bit_cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (frame_n_s) begin
      cnt_q   <= '0;
    end else if (shift_en) begin
      shreg_q <= word[FRAME_BITS-2:0];
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dac_serial_hold.sv
module dac_serial_hold #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] code,
  output logic             strobe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= load;
      if (load) code <= word;
    end
  end

endmodule

// File: rtl/dac_serial_in.sv
module dac_serial_in
  import dac_serial_pkg::*;
#(
  parameter bit WIDE_FRAME  = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_BITS = frame_len(WIDE_FRAME)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk,
  input  logic                  ser_data,
  input  logic                  frame_n,
  output logic [FRAME_BITS-1:0] dac_code,
  output logic                  update_pulse
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  serial_pins_t          pins_raw, pins_s;
  logic                  sclk_fall;
  logic                  frame_n_s;
  logic                  load;
  logic [FRAME_BITS-1:0] word;
  logic [CNT_W-1:0]      bit_cnt;

  assign pins_raw  = '{sclk: ser_clk, sdata: ser_data, frame_n: frame_n};
  assign frame_n_s = pins_s.frame_n;

  dac_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pins_in  (pins_raw),
    .pins_out (pins_s)
  );

  dac_serial_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s.sclk),
    .sclk_fall (sclk_fall)
  );

  dac_serial_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .frame_n_s (frame_n_s),
    .sdata_s   (pins_s.sdata),
    .sclk_fall (sclk_fall),
    .load      (load),
    .word      (word),
    .bit_cnt   (bit_cnt)
  );

  dac_serial_hold #(.WIDTH(FRAME_BITS)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .word   (word),
    .code   (dac_code),
    .strobe (update_pulse)
  );

endmodule

// File: rtl/dac_serial_in_chk.sv
module dac_serial_in_chk #(
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  update_pulse,
  input logic [FRAME_BITS-1:0] dac_code,
  input logic                  frame_n_s,
  input logic [CNT_W-1:0]      bit_cnt
);

  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (dac_code == '0 && !update_pulse)); // R1
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) update_pulse |=> !update_pulse); // R3
  AST_CODE_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (rst) !$stable(dac_code) |-> update_pulse); // R5
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst) bit_cnt <= CNT_W'(FRAME_BITS)); // R6
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst) frame_n_s |=> bit_cnt == '0); // R7
  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst) update_pulse |-> !$past(frame_n_s)); // R8

endmodule

bind dac_serial_in dac_serial_in_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .update_pulse (update_pulse),
  .dac_code     (dac_code),
  .frame_n_s    (frame_n_s),
  .bit_cnt      (bit_cnt)
);

// File: tb/dac_serial_in_test.sv
module dac_serial_in_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic frame_n = 1'b1;
  logic [15:0] code16;
  logic [23:0] code24;
  logic pulse16, pulse24;

  int errors = 0;
  int checks = 0;
  int rise16 = 0, rise24 = 0, high16 = 0, high24 = 0, bad16 = 0, bad24 = 0;
  logic prev_p16 = 1'b0, prev_p24 = 1'b0;
  logic [15:0] prev_c16 = '0;
  logic [23:0] prev_c24 = '0;

  always #2.5 clk = ~clk;

  dac_serial_in #(.WIDE_FRAME(1'b0)) uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .frame_n(frame_n),
    .dac_code(code16), .update_pulse(pulse16)
  );

  dac_serial_in #(.WIDE_FRAME(1'b1)) uut_w (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .frame_n(frame_n),
    .dac_code(code24), .update_pulse(pulse24)
  );

  // Strobe monitor: pulse count, pulse width, and code changes outside a strobe (R3)
  always @(negedge clk) begin
    if (!rst) begin
      if (pulse16) high16++;
      if (pulse24) high24++;
      if (pulse16 && !prev_p16) rise16++;
      if (pulse24 && !prev_p24) rise24++;
      if (code16 !== prev_c16 && !pulse16) bad16++;
      if (code24 !== prev_c24 && !pulse24) bad24++;
    end
    prev_p16 = pulse16; prev_p24 = pulse24;
    prev_c16 = code16;  prev_c24 = code24;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = val[i];
      ser_clk  = 1'b1;
      wait_n(4);
      ser_clk  = 1'b0;
      wait_n(4);
    end
  endtask

  task automatic send_frame(input logic [31:0] val, input int n);
    frame_n = 1'b0;
    wait_n(4);
    shift_bits(val, n);
    wait_n(4);
    frame_n = 1'b1;
    wait_n(8);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] exp16;
    logic [23:0] exp24;
    int p16, p24;
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    check("R1 code16 after reset", 32'(code16), 32'h0);
    check("R1 code24 after reset", 32'(code24), 32'h0);
    check("R1 strobes after reset", {30'h0, pulse16, pulse24}, 32'h0);

    // Sweep of 24-bit frames: walking one and walking zero in the top 16 bits
    for (int k = 0; k < 32; k++) begin
      exp16 = (k < 16) ? 16'(1 << k) : ~16'(1 << (k - 16));
      exp24 = {exp16, 8'(k * 37 + 5)};
      p16 = rise16; p24 = rise24;
      send_frame(32'(exp24), 24);
      check("R2/R6 16-bit code, first 16 bits of 24", 32'(code16), 32'(exp16));
      check("R4 24-bit code", 32'(code24), 32'(exp24));
      check("R3 one strobe per frame (16)", 32'(rise16 - p16), 32'd1);
      check("R3 one strobe per frame (24)", 32'(rise24 - p24), 32'd1);
    end

    // Pure 16-bit frames: short for the wide variant, which must abort
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = 16'(k * 16'h2F1D + 16'h0A53);
      p24 = rise24;
      send_frame(32'(v), 16);
      exp16 = v;
      check("R2 16-bit frame", 32'(code16), 32'(exp16));
      check("R5 wide variant keeps code on short frame", 32'(code24), 32'(exp24));
      check("R5 wide variant no strobe", 32'(rise24 - p24), 32'd0);
    end

    // Abort after 15 bits and after 0 bits
    p16 = rise16;
    send_frame(32'h0000_7FFF, 15);
    check("R5 abort at 15 bits keeps code", 32'(code16), 32'(exp16));
    send_frame(32'h0, 0);
    check("R5 empty frame keeps code", 32'(code16), 32'(exp16));
    check("R5 no strobe on abort", 32'(rise16 - p16), 32'd0);

    // Serial clock toggling with frame enable high
    p16 = rise16; p24 = rise24;
    shift_bits(32'h00AB_CDEF, 24);
    wait_n(8);
    check("R8 code16 unchanged while idle", 32'(code16), 32'(exp16));
    check("R8 code24 unchanged while idle", 32'(code24), 32'(exp24));
    check("R8 no strobes while idle", 32'((rise16 - p16) + (rise24 - p24)), 32'd0);

    // Partial frame, then a full frame assembled from its own bits
    send_frame(32'h0000_03FF, 10);
    send_frame(32'h0000_C3A5, 16);
    exp16 = 16'hC3A5;
    check("R7 fresh frame after partial", 32'(code16), 32'(exp16));
    send_frame(32'h0012_3456, 13);
    send_frame(32'h00FE_DCBA, 24);
    exp24 = 24'hFEDCBA;
    exp16 = 16'hFEDC;
    check("R7 fresh wide frame after partial", 32'(code24), 32'(exp24));
    check("R6 extra bits ignored", 32'(code16), 32'(exp16));

    check("R3 strobe width 16", 32'(high16), 32'(rise16));
    check("R3 strobe width 24", 32'(high24), 32'(rise24));
    check("R3 code16 changes only with strobe", 32'(bad16), 32'd0);
    check("R3 code24 changes only with strobe", 32'(bad24), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule